// File: doc/BRIEF.md
# Cascadable First-Word-Fall-Through FIFO

This block is a dual-clock FIFO stage that runs only in fall-through mode: the oldest stored word sits on the data output whenever the stage holds data, and an active-low output-ready flag marks it as valid. The write side takes words whenever its active-low input-ready flag is asserted. Both flags are timed so that one stage's output side connects straight to the next stage's input side with no glue. The output-ready flag acts as the next stage's write enable, and the next stage's input-ready flag acts as this stage's read enable.

The top wraps `N` such stages into one deeper FIFO. The first stage is written on the external write clock and the last stage is read on the external read clock. Every transfer between stages runs on one transfer clock, which should be the faster of the two. A word written to an empty chain travels to the far end by itself. A slot freed at the far end of a full chain travels back to the entry. Pointers cross between clock domains as Gray code through two-flop synchronizers. `DEPTH` must be a power of two, at least 2.

Top module: `fwft_chain`

## Requirements
- R1: While reset (active low) is asserted, output-ready and input-ready are both high (inactive) and the data output is zero. Input-ready goes low within two write-clock cycles after reset is released.
- R2: A word written to an empty chain appears on the data output without any read request, and output-ready goes low while that word is present.
- R3: Words leave the chain in the order in which they were accepted, under any pattern of write gaps and read stalls.
- R4: The chain accepts exactly N·DEPTH words (24 with 3 stages of 8) while nothing is read. After that, input-ready stays high.
- R5: With all clocks equal, output-ready goes low (N−1)·4 + 3 cycles after the clock edge that accepts the first word into an empty chain. This is 11 cycles for 3 stages.
- R6: With all clocks equal, input-ready goes low (N−1)·3 + 2 cycles after the edge that reads one word from a full chain. This is 8 cycles for 3 stages.
- R7: A write attempted while input-ready is high is ignored: the word never appears at the output and the stored contents are unchanged.
- R8: A read attempted while output-ready is high is ignored. While output-ready is low and no read is requested, output-ready stays low and the data output holds its value.
- R9: Once the chain is primed, with write and read both requested every cycle, one word leaves the chain on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock of the first stage |
| rclk | input | 1 | Read clock of the last stage |
| xclk | input | 1 | Transfer clock between stages |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | W | Write data |
| wen_n | input | 1 | Write enable, active low |
| ir_n | output | 1 | Input ready, active low: at least one slot is free |
| dout | output | W | Oldest word, valid while or_n is low |
| ren_n | input | 1 | Read enable, active low |
| or_n | output | 1 | Output ready, active low: dout holds a valid word |

## Verification
The hardest condition to reach from the ports is a full chain that then frees exactly one slot. The bench must show the vacancy travelling backward through every stage and measure when it reaches the entry. To get there, the bench keeps writing with reads held off until input-ready has stayed high for a long run. By then every internal transfer has settled and all stages are full. It then issues one single-cycle read and counts edges until input-ready falls. The same full state is reused with writes still attempted, to show that those writes leave no trace in the drained stream. A fill-latency measurement from a cold chain and table-driven streams with masked write gaps and read stalls cover ordering and throughput.

// File: rtl/fwft_chain.sv
module fwft_stage #(
  parameter int W     = 36,
  parameter int DEPTH = 8
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         wen_n,
  output logic         ir_n,
  output logic [W-1:0] dout,
  input  logic         ren_n,
  output logic         or_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic [PW-1:0] fbin, rbin, rgray, wg_s1, wg_s2;
  logic          up;

  wire [PW-1:0] wnext = wbin + 1'b1;
  wire [PW-1:0] rnext = rbin + 1'b1;
  wire full   = (wbin - g2b(rg_s2)) == PW'(DEPTH);
  wire wr_ok  = !wen_n && !ir_n;
  wire rd_ok  = !ren_n && !or_n;
  wire avail  = fbin != g2b(wg_s2);
  wire load   = avail && (or_n || rd_ok);

  assign ir_n = !(up && !full);

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
      up    <= 1'b0;
    end else begin
      up    <= 1'b1;
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_ok) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end

  always_ff @(posedge wclk)
    if (wr_ok) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      fbin  <= '0;
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
      dout  <= '0;
      or_n  <= 1'b1;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (rd_ok) begin
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
      if (load) begin
        dout <= mem[fbin[AW-1:0]];
        fbin <= fbin + 1'b1;
        or_n <= 1'b0;
      end else if (rd_ok) begin
        or_n <= 1'b1;
      end
    end
endmodule

module fwft_chain #(
  parameter int W     = 36,
  parameter int DEPTH = 8,
  parameter int N     = 3
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         xclk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         wen_n,
  output logic         ir_n,
  output logic [W-1:0] dout,
  input  logic         ren_n,
  output logic         or_n
);
  logic [N:0][W-1:0] dat;
  logic [N:0]        vld_n;
  logic [N:0]        spc_n;

  assign dat[0]   = din;
  assign vld_n[0] = wen_n;
  assign spc_n[N] = ren_n;
  assign dout     = dat[N];
  assign or_n     = vld_n[N];
  assign ir_n     = spc_n[0];

  for (genvar i = 0; i < N; i++) begin : g_stage
    wire ck_w = (i == 0)     ? wclk : xclk;
    wire ck_r = (i == N - 1) ? rclk : xclk;
    fwft_stage #(.W(W), .DEPTH(DEPTH)) u_stage (
      .wclk  (ck_w),
      .rclk  (ck_r),
      .rst_n (rst_n),
      .din   (dat[i]),
      .wen_n (vld_n[i]),
      .ir_n  (spc_n[i]),
      .dout  (dat[i+1]),
      .ren_n (spc_n[i+1]),
      .or_n  (vld_n[i+1])
    );
  end
endmodule

// File: rtl/fwft_chain_chk.sv
module fwft_chain_chk #(
  parameter int W = 36
) (
  input logic         wclk,
  input logic         rclk,
  input logic         rst_n,
  input logic         wen_n,
  input logic         ir_n,
  input logic         ren_n,
  input logic         or_n,
  input logic [W-1:0] dout
);
  // R1
  always @(posedge rclk)
    if (!rst_n) reset_state_chk: assert (or_n && ir_n && dout == '0);

  // R8
  held_word_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!or_n && ren_n) |=> (!or_n && $stable(dout)));

  // R8
  empty_only_by_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $rose(or_n) |-> $past(!ren_n));

  // R4
  full_only_by_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(ir_n) |-> $past(!wen_n));
endmodule

bind fwft_chain fwft_chain_chk #(.W(W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ir_n(ir_n),
  .ren_n(ren_n), .or_n(or_n), .dout(dout)
);

// File: tb/test_fwft_chain.sv
`timescale 1ns/1ps
module test_fwft_chain;
  localparam int W = 36, DEPTH = 8, N = 3;
  localparam int FILL_LAT  = (N - 1) * 4 + 3;
  localparam int DRAIN_LAT = (N - 1) * 3 + 2;
  localparam logic [W-1:0] MARK = 36'hBAD_0000_0;
  // {word count, write-gap mask, read-stall mask}
  localparam logic [23:0] VEC [6] = '{24'h28_00_00, 24'h3C_00_5A, 24'h32_A5_00,
                                      24'h50_11_EE, 24'h1E_7F_00, 24'h40_36_C9};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic wen_n = 1'b1, ren_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic ir_n, or_n;
  logic [W-1:0] q[$];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  fwft_chain #(.W(W), .DEPTH(DEPTH), .N(N)) i_fwft_chain (
    .wclk(clk), .rclk(clk), .xclk(clk), .rst_n(rst_n), .din(din),
    .wen_n(wen_n), .ir_n(ir_n), .dout(dout), .ren_n(ren_n), .or_n(or_n));

  function automatic logic [W-1:0] pat(int k);
    return {k[3:0], 32'(k) * 32'h9E3779B1};
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic pop_chk(string req);
    if (q.size() == 0) chk(0, req, dout, '0);
    else begin
      chk(dout == q[0], req, dout, q[0]);
      void'(q.pop_front());
    end
  endtask

  task automatic run_stream(int n, logic [7:0] wm, logic [7:0] rm, int base);
    int sent = 0, got = 0, cyc = 0;
    while (got < n && cyc < 5000) begin
      @(negedge clk);
      if (sent < n && !wm[cyc % 8]) begin
        wen_n = 1'b0;
        din = pat(base + sent);
        if (!ir_n) begin q.push_back(din); sent++; end
      end else wen_n = 1'b1;
      if (!rm[cyc % 8]) begin
        ren_n = 1'b0;
        if (!or_n) begin pop_chk("R3 order"); got++; end
      end else ren_n = 1'b1;
      cyc++;
    end
    @(negedge clk);
    wen_n = 1'b1; ren_n = 1'b1;
    chk(got == n, "R3 count", 36'(got), 36'(n));
  endtask

  task automatic drain(string req);
    int cyc = 0;
    while (q.size() > 0 && cyc < 2000) begin
      @(negedge clk);
      if (!or_n) begin ren_n = 1'b0; pop_chk(req); end
      else ren_n = 1'b1;
      cyc++;
    end
    @(negedge clk);
    ren_n = 1'b1;
  endtask

  task automatic fill_full(int base, bit mark, output int acc);
    int hi = 0;
    acc = 0;
    while (hi < 40) begin
      @(negedge clk);
      wen_n = 1'b0;
      if (!ir_n) begin
        din = pat(base + acc); q.push_back(din); acc++; hi = 0;
      end else begin
        din = mark ? MARK : pat(base + acc); hi++;
      end
    end
    @(negedge clk);
    wen_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual timeout expected completion");
    report();
  end

  initial begin
    int lat, acc, rd;
    logic [W-1:0] held;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(or_n == 1'b1, "R1 or_n in reset", 36'(or_n), 36'd1);
    chk(ir_n == 1'b1, "R1 ir_n in reset", 36'(ir_n), 36'd1);
    chk(dout == '0, "R1 dout in reset", dout, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ir_n == 1'b0, "R1 ir_n after reset", 36'(ir_n), 36'd0);

    // stimulus table
    for (int i = 0; i < 6; i++)
      run_stream(int'(VEC[i][23:16]), VEC[i][15:8], VEC[i][7:0], 1000 * (i + 1));

    // R8: read on empty chain is ignored
    @(negedge clk); ren_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(or_n == 1'b1, "R8 read while empty", 36'(or_n), 36'd1);
    ren_n = 1'b1;

    // R5 / R2: fill latency, no read request
    wen_n = 1'b0; din = pat(7);
    @(negedge clk); wen_n = 1'b1;
    lat = -1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (!or_n && lat < 0) lat = k;
    end
    chk(lat == FILL_LAT, "R5 fill latency", 36'(lat), 36'(FILL_LAT));
    chk(!or_n && dout == pat(7), "R2 fall-through word", dout, pat(7));
    held = dout;
    repeat (6) @(negedge clk);
    chk(!or_n && dout == held, "R8 held word", dout, held);
    ren_n = 1'b0;
    @(negedge clk); ren_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(or_n == 1'b1, "R8 empty after read", 36'(or_n), 36'd1);

    // R4 / R7: capacity, writes attempted while full carry a marker
    fill_full(200, 1'b1, acc);
    chk(acc == N * DEPTH, "R4 capacity", 36'(acc), 36'(N * DEPTH));
    chk(ir_n == 1'b1, "R4 ir_n full", 36'(ir_n), 36'd1);

    // R6: drain latency from one read
    ren_n = 1'b0; pop_chk("R6 first word");
    @(negedge clk); ren_n = 1'b1;
    lat = -1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (!ir_n && lat < 0) lat = k;
    end
    chk(lat == DRAIN_LAT, "R6 drain latency", 36'(lat), 36'(DRAIN_LAT));
    drain("R7 no marker in stream");
    repeat (4) @(negedge clk);
    chk(or_n == 1'b1, "R7 nothing extra stored", 36'(or_n), 36'd1);

    // R9: full chain, read and write every cycle
    fill_full(400, 1'b0, acc);
    rd = 0;
    acc = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      wen_n = 1'b0; din = pat(600 + acc);
      if (!ir_n) begin q.push_back(din); acc++; end
      ren_n = 1'b0;
      if (!or_n) begin pop_chk("R9 order"); rd++; end
    end
    @(negedge clk); wen_n = 1'b1; ren_n = 1'b1;
    chk(rd == 50, "R9 one word per cycle", 36'(rd), 36'd50);
    drain("R9 tail order");
    report();
  end
endmodule